// File: doc/BRIEF.md
# Paged Processor Access Port for a Time-Slot Switch

This block sits between a simple strobe-driven processor bus and the memories of a time-slot interchange core. The processor side has an active-low chip select, an active-high data strobe, a read/write line, six address lines, separate 8-bit data-in and data-out buses with an output-enable, and an active-low acknowledge. Internally the block keeps one 8-bit control register. That register selects a memory page and holds a routing mode. From the register fields and the low address lines it forms the full memory address, and it sends each access to the data memory, the low connection memory or the high connection memory of the switch core.

The core side is a request/grant port. The block raises a request with a fixed target, address and write data, and holds them until the core grants a slot. After a target-dependent number of wait cycles it captures read data. Accesses to the control register never touch the core. Accesses that address nothing are dropped but still acknowledged. The acknowledge is released only after the strobe is withdrawn, so a processor with any bus speed can complete a handshake.

The strobe qualification (chip select low and data strobe high) passes through a short synchronizer. The address, read/write and write data must therefore be stable from the strobe edge until the acknowledge.

Top module: `pap_port`

## Requirements
- R1: Address bit 5 low selects the control register. A write stores all 8 bits of the data-in bus. A read returns the stored byte. The register resets to 0x00.
- R2: Address bit 5 high starts a memory access at `mem_addr = {control[2:0], addr[4:0]}`, so the control register's stream field names the page.
- R3: Control bits 4:3 select the memory, and `mem_tgt` uses the same code: 01 = data memory, 10 = low connection memory, 11 = high connection memory.
- R4: When control bit 7 (split) is 1, memory reads go to the data memory and memory writes go to the low connection memory, whatever bits 4:3 hold. The page still comes from bits 2:0.
- R5: A memory write with code 01 (split clear) raises no request and changes nothing. Any memory access with code 00 (split clear) raises no request. Both are still acknowledged, and a read with code 00 returns 0x00.
- R6: An access starts only while chip select is low and data strobe is high. With chip select high the strobe causes no request, no acknowledge and no register change.
- R7: `ack_n` goes low only once the transfer has completed. It then stays low for as long as the strobe stays active, and returns high after the strobe is removed.
- R8: A memory request is held, with stable address and target, until `mem_gnt` is seen. No acknowledge is given before the grant.
- R9: Measured from strobe to acknowledge, a control-register access is faster than a connection-memory access, and a connection-memory access is faster than a data-memory read.
- R10: `d_oe` is high only while a read is being acknowledged, and then `d_out` carries the read data. `d_oe` is never high for a write.
- R11: `msg_en` follows control bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ds | input | 1 | Data strobe, active high |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Bit 5: register/memory; bits 4:0: channel |
| d_in | input | 8 | Write data from processor |
| d_out | output | 8 | Read data to processor |
| d_oe | output | 1 | Drive enable for read data |
| ack_n | output | 1 | Transfer acknowledge, active low (1 = released) |
| msg_en | output | 1 | Message-enable bit of the control register |
| mem_req | output | 1 | Memory access request to the core |
| mem_we | output | 1 | Request is a write |
| mem_tgt | output | 2 | Target memory code (01 DM, 10 CML, 11 CMH) |
| mem_addr | output | 8 | Page and channel address |
| mem_wdata | output | 8 | Write data to the core |
| mem_gnt | input | 1 | Core grants the pending request |
| mem_rdata | input | 8 | Read data from the core |

## Verification
The bench targets split routing in both directions.
- A split write is read back through the low connection memory after split is cleared. A design that routed split writes by the select code would return stale data there.
- A write to the read-only data memory is followed by a read of the same location. A design that forwarded such writes would corrupt it.
- A reserved-code read must return zero without a request, which exposes a design that falls through to the data memory.

The bench also withholds the grant for many cycles, holds the strobe after the acknowledge, and compares latencies across the three kinds of target. These checks catch an acknowledge issued early, one released while the strobe is still high, or a latency order that has been swapped.

// File: rtl/pap_pkg.sv
package pap_pkg;

    localparam int DATA_W     = 8;
    localparam int CHAN_W     = 5;
    localparam int STREAM_W   = 3;
    localparam int ADDR_W     = CHAN_W + 1;
    localparam int MEM_ADDR_W = STREAM_W + CHAN_W;

    typedef enum logic [1:0] {
        SEL_RSVD = 2'b00,
        SEL_DM   = 2'b01,
        SEL_CML  = 2'b10,
        SEL_CMH  = 2'b11
    } mem_sel_e;

    typedef struct packed {
        logic                split;
        logic                msg_en;
        logic                spare;
        mem_sel_e            msel;
        logic [STREAM_W-1:0] page;
    } ctrl_t;

    typedef enum logic [1:0] {
        K_CTRL = 2'd0,
        K_MEM  = 2'd1,
        K_DROP = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e                 kind;
        mem_sel_e              tgt;
        logic [MEM_ADDR_W-1:0] maddr;
    } route_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } st_e;

    // Decide where an access goes, given the address lines and the register.
    function automatic route_t route_access(logic [ADDR_W-1:0] a, logic is_rd, ctrl_t c);
        route_t r;
        r.maddr = {c.page, a[CHAN_W-1:0]};
        r.tgt   = c.msel;
        r.kind  = K_MEM;
        if (!a[CHAN_W]) begin
            r.kind = K_CTRL;
            r.tgt  = SEL_RSVD;
        end else if (c.split) begin
            r.tgt = is_rd ? SEL_DM : SEL_CML;
        end else if (c.msel == SEL_RSVD) begin
            r.kind = K_DROP;
        end else if (c.msel == SEL_DM && !is_rd) begin
            r.kind = K_DROP;
        end
        return r;
    endfunction

endpackage

// File: rtl/pap_strobe_sync.sv
module pap_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic q_r;
            always_ff @(posedge clk) begin
                if (rst) q_r <= 1'b0;
                else     q_r <= d;
            end
            assign q = q_r;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
            assign q = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/pap_ctrl_reg.sv
module pap_ctrl_reg
    import pap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= ctrl_t'(wdata);
    end
endmodule

// File: rtl/pap_access_fsm.sv
module pap_access_fsm
    import pap_pkg::*;
#(
    parameter int CM_LAT = 1,
    parameter int DM_LAT = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sel_sync,
    input  logic                  is_rd_in,
    input  logic [DATA_W-1:0]     wdata_in,
    input  route_t                route_in,
    input  ctrl_t                 ctrl_q,
    output logic                  ctrl_we,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [1:0]            mem_tgt,
    output logic [MEM_ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic                  mem_gnt,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  ack_n,
    output logic [DATA_W-1:0]     d_out,
    output logic                  d_oe
);
    localparam int MAX_LAT = (DM_LAT > CM_LAT) ? DM_LAT : CM_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    st_e               state;
    logic              rd_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] rdata_q;
    route_t            rt_q;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_load;

    assign cnt_load = (rt_q.tgt == SEL_DM) ? CNT_W'(DM_LAT - 1) : CNT_W'(CM_LAT - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            rd_q    <= 1'b0;
            wd_q    <= '0;
            rdata_q <= '0;
            rt_q    <= '0;
            cnt     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (sel_sync) begin
                        rd_q <= is_rd_in;
                        wd_q <= wdata_in;
                        rt_q <= route_in;
                        case (route_in.kind)
                            K_CTRL: begin
                                rdata_q <= DATA_W'(ctrl_q);
                                state   <= ST_DONE;
                            end
                            K_MEM:   state <= ST_REQ;
                            default: begin
                                rdata_q <= '0;
                                state   <= ST_DONE;
                            end
                        endcase
                    end
                end
                ST_REQ: begin
                    if (mem_gnt) begin
                        cnt   <= cnt_load;
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (cnt == '0) begin
                        if (rd_q) rdata_q <= mem_rdata;
                        state <= ST_DONE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (!sel_sync) state <= ST_IDLE;
                end
            endcase
        end
    end

    assign ctrl_we   = (state == ST_IDLE) && sel_sync && (route_in.kind == K_CTRL) && !is_rd_in;
    assign mem_req   = (state == ST_REQ);
    assign mem_we    = (state == ST_REQ) && !rd_q;
    assign mem_tgt   = rt_q.tgt;
    assign mem_addr  = rt_q.maddr;
    assign mem_wdata = wd_q;
    assign ack_n     = (state != ST_DONE);
    assign d_oe      = (state == ST_DONE) && rd_q;
    assign d_out     = rdata_q;

    // R8: a pending request keeps its address and target until granted
    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_tgt)));

    // R7: acknowledge is held while the strobe stays active
    p_ack_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!ack_n && sel_sync) |=> !ack_n);

    // R7: acknowledge is released once the strobe has gone
    p_ack_release_r7: assert property (@(posedge clk) disable iff (rst)
        (!ack_n && !sel_sync) |=> ack_n);
endmodule

// File: rtl/pap_port.sv
module pap_port
    import pap_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CM_LAT      = 1,
    parameter int DM_LAT      = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_n,
    input  logic                  ds,
    input  logic                  rw,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     d_in,
    output logic [DATA_W-1:0]     d_out,
    output logic                  d_oe,
    output logic                  ack_n,
    output logic                  msg_en,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [1:0]            mem_tgt,
    output logic [MEM_ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic                  mem_gnt,
    input  logic [DATA_W-1:0]     mem_rdata
);
    logic   sel_sync;
    logic   ctrl_we;
    ctrl_t  ctrl_q;
    route_t route;

    pap_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (!cs_n && ds),
        .q   (sel_sync)
    );

    pap_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctrl_we),
        .wdata (d_in),
        .q     (ctrl_q)
    );

    assign route  = route_access(addr, rw, ctrl_q);
    assign msg_en = ctrl_q.msg_en;

    pap_access_fsm #(.CM_LAT(CM_LAT), .DM_LAT(DM_LAT)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sel_sync  (sel_sync),
        .is_rd_in  (rw),
        .wdata_in  (d_in),
        .route_in  (route),
        .ctrl_q    (ctrl_q),
        .ctrl_we   (ctrl_we),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_tgt   (mem_tgt),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_gnt   (mem_gnt),
        .mem_rdata (mem_rdata),
        .ack_n     (ack_n),
        .d_out     (d_out),
        .d_oe      (d_oe)
    );

    // R4: with split set, every memory read goes to the data memory
    p_split_read_dm_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && ctrl_q.split) |-> (mem_tgt == SEL_DM));

    // R5: the data memory and the reserved code never receive a write
    p_dm_no_write_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_tgt == SEL_CML || mem_tgt == SEL_CMH));

    // R2: the page of every request matches the register stream field
    p_page_addr_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[MEM_ADDR_W-1:CHAN_W] == ctrl_q.page));
endmodule

// File: tb/tb_pap_port.sv
module tb_pap_port;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 60;
    localparam int NVEC       = 21;

    // entry: {rd, addr[5:0], data[7:0], expect_request}
    localparam logic [15:0] VEC [0:NVEC-1] = '{
        {1'b0, 6'h00, 8'h0A, 1'b0},  // R1 write ctrl: DM, page 2
        {1'b1, 6'h00, 8'h0A, 1'b0},  // R1 read back
        {1'b1, 6'h25, 8'hE0, 1'b1},  // R2 R3 DM read page2 ch5 (69^A5)
        {1'b0, 6'h00, 8'h13, 1'b0},  // CML page 3
        {1'b0, 6'h27, 8'h5C, 1'b1},  // R3 CML write ch7
        {1'b1, 6'h27, 8'h5C, 1'b1},  // R3 CML read back
        {1'b0, 6'h00, 8'h1D, 1'b0},  // CMH page 5
        {1'b0, 6'h3F, 8'h47, 1'b1},  // R3 CMH write ch31
        {1'b1, 6'h3F, 8'h47, 1'b1},  // R3 CMH read back
        {1'b0, 6'h00, 8'h81, 1'b0},  // R4 split, code 00, page 1
        {1'b0, 6'h20, 8'h99, 1'b1},  // R4 split write -> CML
        {1'b1, 6'h20, 8'h85, 1'b1},  // R4 split read -> DM (32^A5)
        {1'b0, 6'h00, 8'h11, 1'b0},  // split off, CML page 1
        {1'b1, 6'h20, 8'h99, 1'b1},  // R4 split write landed in CML
        {1'b0, 6'h00, 8'h0F, 1'b0},  // DM page 7
        {1'b0, 6'h23, 8'hEE, 1'b0},  // R5 DM write dropped
        {1'b1, 6'h23, 8'h46, 1'b1},  // R5 DM unchanged (227^A5)
        {1'b0, 6'h00, 8'h07, 1'b0},  // reserved code, page 7
        {1'b1, 6'h23, 8'h00, 1'b0},  // R5 reserved read gives zero
        {1'b0, 6'h00, 8'h57, 1'b0},  // R11 message enable on
        {1'b1, 6'h00, 8'h57, 1'b0}   // R1 read back
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, ds = 1'b0, rw = 1'b1;
    logic [5:0] addr = '0;
    logic [7:0] d_in = '0;
    logic [7:0] d_out;
    logic       d_oe, ack_n, msg_en;
    logic       mem_req, mem_we, mem_gnt;
    logic [1:0] mem_tgt;
    logic [7:0] mem_addr, mem_wdata;
    logic [7:0] mem_rdata;
    logic       gnt_en = 1'b1;

    logic [7:0] dm  [0:255];
    logic [7:0] cml [0:255];
    logic [7:0] cmh [0:255];

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pap_port dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ds(ds), .rw(rw), .addr(addr),
        .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .ack_n(ack_n), .msg_en(msg_en),
        .mem_req(mem_req), .mem_we(mem_we), .mem_tgt(mem_tgt), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    // core model
    assign mem_gnt = gnt_en && mem_req;
    always_comb begin
        case (mem_tgt)
            2'b01:   mem_rdata = dm[mem_addr];
            2'b10:   mem_rdata = cml[mem_addr];
            2'b11:   mem_rdata = cmh[mem_addr];
            default: mem_rdata = 8'hXX;
        endcase
    end
    always @(posedge clk) begin
        if (mem_req && mem_gnt && mem_we) begin
            case (mem_tgt)
                2'b01:   dm[mem_addr]  <= mem_wdata;
                2'b10:   cml[mem_addr] <= mem_wdata;
                2'b11:   cmh[mem_addr] <= mem_wdata;
                default: ;
            endcase
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one processor cycle; returns data, latency, request seen
    task automatic bus(input logic rd, input logic [5:0] a, input logic [7:0] d,
                       output logic [7:0] rdat, output logic oe, output int lat,
                       output logic saw_req);
        saw_req = 1'b0;
        lat = 0;
        @(negedge clk);
        rw = rd; addr = a; d_in = d; cs_n = 1'b0; ds = 1'b1;
        while (ack_n && lat < LIMIT) begin
            @(negedge clk);
            lat++;
            if (mem_req) saw_req = 1'b1;
        end
        rdat = d_out;
        oe = d_oe;
        ds = 1'b0; cs_n = 1'b1;
        for (int i = 0; i < LIMIT && !ack_n; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rdat;
        logic oe, sr;
        int lat, lat_ctrl, lat_cm, lat_dm;
        for (int i = 0; i < 256; i++) begin
            dm[i] = 8'(i) ^ 8'hA5; cml[i] = 8'h00; cmh[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state (R1, R7, R10, R11)
        chk(ack_n == 1'b1, "R7 reset ack released", ack_n, 1);
        chk(d_oe == 1'b0, "R10 reset no drive", d_oe, 0);
        chk(msg_en == 1'b0, "R11 reset msg_en", msg_en, 0);
        bus(1'b1, 6'h00, 8'h00, rdat, oe, lat, sr);
        chk(rdat == 8'h00, "R1 reset ctrl value", rdat, 0);

        // vector walk
        for (int v = 0; v < NVEC; v++) begin
            logic vrd; logic [5:0] va; logic [7:0] vd; logic vreq;
            {vrd, va, vd, vreq} = VEC[v];
            bus(vrd, va, vd, rdat, oe, lat, sr);
            chk(lat < LIMIT, $sformatf("R7 vec%0d ack seen", v), lat, LIMIT);
            chk(sr == vreq, $sformatf("R2/R5 vec%0d request", v), sr, vreq);
            chk(oe == vrd, $sformatf("R10 vec%0d d_oe", v), oe, vrd);
            if (vrd) chk(rdat == vd, $sformatf("R1-vec%0d read data", v), rdat, vd);
        end
        chk(msg_en == 1'b1, "R11 msg_en set", msg_en, 1);
        chk(cmh[8'hBF] == 8'h47, "R2 CMH page5 ch31 written", cmh[8'hBF], 8'h47);
        chk(cml[8'h20] == 8'h99, "R4 split write in CML", cml[8'h20], 8'h99);

        // R6: chip select high ignores the strobe
        @(negedge clk);
        rw = 1'b0; addr = 6'h00; d_in = 8'hFF; cs_n = 1'b1; ds = 1'b1;
        sr = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!ack_n || mem_req) sr = 1'b1;
        end
        ds = 1'b0;
        chk(sr == 1'b0, "R6 no activity without chip select", sr, 0);
        repeat (3) @(negedge clk);
        bus(1'b1, 6'h00, 8'h00, rdat, oe, lat, sr);
        chk(rdat == 8'h57, "R6 ctrl unchanged", rdat, 8'h57);

        // R9 latency ordering: ctrl, CML read, DM read
        lat_ctrl = lat;
        bus(1'b0, 6'h00, 8'h12, rdat, oe, lat, sr);   // CML page 2
        bus(1'b1, 6'h21, 8'h00, rdat, oe, lat_cm, sr);
        bus(1'b0, 6'h00, 8'h0A, rdat, oe, lat, sr);   // DM page 2
        bus(1'b1, 6'h21, 8'h00, rdat, oe, lat_dm, sr);
        chk(rdat == 8'h41 ^ 8'hA5, "R9 DM read data", rdat, 8'h41 ^ 8'hA5);
        chk(lat_ctrl < lat_cm, "R9 ctrl faster than CM", lat_ctrl, lat_cm);
        chk(lat_cm < lat_dm, "R9 CM faster than DM", lat_cm, lat_dm);

        // R8: grant withheld, request held, no acknowledge
        bus(1'b0, 6'h00, 8'h13, rdat, oe, lat, sr);   // CML page 3
        gnt_en = 1'b0;
        @(negedge clk);
        rw = 1'b1; addr = 6'h27; cs_n = 1'b0; ds = 1'b1;
        repeat (6) @(negedge clk);
        sr = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!ack_n || !mem_req || mem_addr != 8'h67) sr = 1'b0;
        end
        chk(sr == 1'b1, "R8 waits for grant", sr, 1);
        gnt_en = 1'b1;
        lat = 0;
        while (ack_n && lat < LIMIT) begin @(negedge clk); lat++; end
        chk(!ack_n && d_out == 8'h5C, "R8 data after grant", d_out, 8'h5C);
        // R7: acknowledge held while strobe stays
        sr = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (ack_n || !d_oe) sr = 1'b0;
        end
        chk(sr == 1'b1, "R7 ack held with strobe", sr, 1);
        ds = 1'b0; cs_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(ack_n == 1'b1 && d_oe == 1'b0, "R7 ack released", ack_n, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule